// File: doc/BRIEF.md
# External Bus Idle-Cycle Inserter

This block sequences read and write cycles on an external parallel bus whose address space is split into numbered areas, each with its own chip select. A cycle takes two states (T1, T2) on a fast area or three (T1, T2, T3) on an area marked slow. When one cycle follows another without a pause and the pair carries a turnaround hazard, the block adds one idle state (TI) ahead of the second cycle. A hazard exists when the first cycle was a read and the second is either a read to another area or a write. The gap gives a device that is slow to float its data outputs time to release the shared data bus before the next device, or this block's own write driver, takes it.

Requests arrive on a valid/ready handshake with an area number, a direction flag, an address and write data. Two enable bits select which of the two hazards get a gap. Both come up set after reset and are loaded together from configuration inputs on a load strobe. The bus side presents the address, write data with its output enable, one chip select per area, read and write strobes, and an encoded state indicator.

Top module: `ebus_idle_seq`

## Requirements
- R1: While reset is asserted and right after it is released, the state indicator reads IDLE (0), `req_ready` is 1 and no chip select, read strobe, write strobe or data output enable is active.
- R2: The state indicator encodes IDLE=0, TI=1, T1=2, T2=3, T3=4. An accepted cycle runs T1 then T2, then T3 only when the area's bit in `SLOW_MASK` is 1. `bus_addr` carries the accepted address from T1 to the cycle's end.
- R3: On a read, `bus_rd` and the chip select whose index equals the area number are active from T1 through the last state. No chip select and no strobe is active in TI or IDLE.
- R4: On a write, `bus_wr` is active only in T2 and T3, never in T1. `bus_dout_oe` is active from T1 through the last state and `bus_dout` carries the accepted write data.
- R5: `req_ready` is 1 only in IDLE or in the final state of a cycle (T2 of a fast area, T3 of a slow area). A request is taken on a clock edge where `req_valid` and `req_ready` are both 1.
- R6: With the area-change enable at 1, a read taken back-to-back after a read to a different area is preceded by exactly one TI state, followed by its T1.
- R7: With the area-change enable at 0, a read after a read to a different area starts at T1 straight after the previous cycle's last state.
- R8: A read after a read to the same area, and a read after a write, never get a TI state.
- R9: A write taken back-to-back after a read gets one TI state when the write-after-read enable is 1 and none when it is 0.
- R10: Both enables are 1 after reset. On a clock edge with `cfg_load` high they take the values of `cfg_rr_gap_en` and `cfg_wr_gap_en`. The new values apply to decisions from the next edge on.
- R11: A request taken while the bus is IDLE, including the first one after reset, starts at T1 with no TI state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Loads both gap enables on this edge |
| cfg_rr_gap_en | input | 1 | New value of the area-change read enable |
| cfg_wr_gap_en | input | 1 | New value of the write-after-read enable |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this edge |
| req_area | input | AREA_W | Target area number |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | ADDR_W | Cycle address |
| req_wdata | input | DATA_W | Write data |
| bus_addr | output | ADDR_W | Address bus |
| bus_dout | output | DATA_W | Write data to the data bus |
| bus_dout_oe | output | 1 | Data bus output enable |
| bus_cs | output | NUM_AREAS | Per-area chip selects |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_state | output | 3 | Current bus state code |

## Verification
All bus outputs decode the state register and the captured cycle fields, so every output moves exactly one edge after the accepting or advancing edge. A TI state appears in the cycle right after the final-state edge that took the hazardous request, and the new cycle's T1 follows one cycle later. The bench drives inputs and reads outputs on the falling edge. At each falling edge it first compares the outputs with a behavioural model of the state reached on the previous rising edge, then drives new inputs and advances the model with what the next rising edge will see. Each scenario also counts the TI states it observes and compares the count with a value derived by hand from the requirements.

// File: rtl/ebus_seq_pkg.sv
package ebus_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_TI   = 3'd1,
      ST_T1   = 3'd2,
      ST_T2   = 3'd3,
      ST_T3   = 3'd4
   } bstate_e;
endpackage

// File: rtl/ebus_gap_cfg.sv
module ebus_gap_cfg (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic rr_in,
   input  logic wr_in,
   output logic rr_en,
   output logic wr_en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_en <= 1'b1;
         wr_en <= 1'b1;
      end else if (load) begin
         rr_en <= rr_in;
         wr_en <= wr_in;
      end
   end

   // R10: a load strobe copies both inputs
   a_r10_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (rr_en == $past(rr_in) && wr_en == $past(wr_in)));
   // R10: without a load the enables hold
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(rr_en) && $stable(wr_en)));
endmodule

// File: rtl/ebus_gap_judge.sv
module ebus_gap_judge #(
   parameter int AREA_W = 3
) (
   input  logic              back2back,
   input  logic              prev_read,
   input  logic [AREA_W-1:0] prev_area,
   input  logic              nxt_read,
   input  logic [AREA_W-1:0] nxt_area,
   input  logic              rr_en,
   input  logic              wr_en,
   output logic              gap_need
);
   logic area_moves;
   logic hazard;

   always_comb begin
      area_moves = (nxt_area != prev_area);
      if (nxt_read) hazard = rr_en & area_moves;
      else          hazard = wr_en;
      gap_need = back2back & prev_read & hazard;
   end
endmodule

// File: rtl/ebus_cycle_fsm.sv
module ebus_cycle_fsm
   import ebus_seq_pkg::*;
#(
   parameter int                    NUM_AREAS = 8,
   parameter int                    AREA_W    = 3,
   parameter int                    ADDR_W    = 16,
   parameter int                    DATA_W    = 16,
   parameter logic [NUM_AREAS-1:0]  SLOW_MASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_read,
   input  logic [AREA_W-1:0] req_area,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              gap_need,
   output logic              req_ready,
   output logic              accept,
   output logic              back2back,
   output bstate_e           state,
   output logic              cur_read,
   output logic [AREA_W-1:0] cur_area,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [DATA_W-1:0] cur_data
);
   bstate_e nxt;
   logic    cur_slow;

   generate
      if (SLOW_MASK == '0) begin : g_all_fast
         assign cur_slow = 1'b0;
      end else begin : g_lookup
         assign cur_slow = SLOW_MASK[cur_area];
      end
   endgenerate

   always_comb begin
      req_ready = (state == ST_IDLE) || (state == ST_T3) ||
                  ((state == ST_T2) && !cur_slow);
      accept    = req_valid & req_ready;
      back2back = (state != ST_IDLE);
   end

   always_comb begin
      nxt = ST_IDLE;
      if (accept) begin
         nxt = gap_need ? ST_TI : ST_T1;
      end else begin
         unique case (state)
            ST_TI:   nxt = ST_T1;
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = cur_slow ? ST_T3 : ST_IDLE;
            default: nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cur_read <= 1'b0;
         cur_area <= '0;
         cur_addr <= '0;
         cur_data <= '0;
      end else begin
         state <= nxt;
         if (accept) begin
            cur_read <= req_read;
            cur_area <= req_area;
            cur_addr <= req_addr;
            cur_data <= req_wdata;
         end
      end
   end

   // R2: T1 is always followed by T2
   a_r2_t1_then_t2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_T1) |=> (state == ST_T2));
   // R2: T3 only on slow areas
   a_r2_t3_slow_only: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_T3) |-> SLOW_MASK[cur_area]);
   // R6: an idle state lasts one cycle and leads into T1
   a_r6_ti_then_t1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TI) |=> (state == ST_T1));
   // R5: no request taken in TI or T1
   a_r5_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TI || state == ST_T1) |-> !req_ready);
   // R11: a request met in IDLE starts straight at T1
   a_r11_idle_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && req_valid) |=> (state == ST_T1));
endmodule

// File: rtl/ebus_strobe_gen.sv
module ebus_strobe_gen
   import ebus_seq_pkg::*;
#(
   parameter int NUM_AREAS = 8,
   parameter int AREA_W    = 3,
   parameter bit ACT_LOW   = 1'b0
) (
   input  bstate_e              state,
   input  logic                 cur_read,
   input  logic [AREA_W-1:0]    cur_area,
   output logic [NUM_AREAS-1:0] cs,
   output logic                 rd,
   output logic                 wr,
   output logic                 oe
);
   logic                 in_cycle;
   logic                 strobe_ph;
   logic [NUM_AREAS-1:0] cs_raw;
   logic                 rd_raw;
   logic                 wr_raw;

   always_comb begin
      in_cycle  = (state == ST_T1) || (state == ST_T2) || (state == ST_T3);
      strobe_ph = (state == ST_T2) || (state == ST_T3);
      rd_raw    = in_cycle & cur_read;
      wr_raw    = strobe_ph & ~cur_read;
      oe        = in_cycle & ~cur_read;
   end

   genvar gi;
   generate
      for (gi = 0; gi < NUM_AREAS; gi++) begin : g_cs
         assign cs_raw[gi] = in_cycle && (cur_area == AREA_W'(gi));
      end
      if (ACT_LOW) begin : g_low
         assign cs = ~cs_raw;
         assign rd = ~rd_raw;
         assign wr = ~wr_raw;
      end else begin : g_high
         assign cs = cs_raw;
         assign rd = rd_raw;
         assign wr = wr_raw;
      end
   endgenerate
endmodule

// File: rtl/ebus_idle_seq.sv
module ebus_idle_seq
   import ebus_seq_pkg::*;
#(
   parameter int                   NUM_AREAS = 8,
   parameter int                   ADDR_W    = 16,
   parameter int                   DATA_W    = 16,
   parameter logic [NUM_AREAS-1:0] SLOW_MASK = 8'b0000_0101,
   parameter bit                   ACT_LOW   = 1'b0,
   localparam int                  AREA_W    = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_load,
   input  logic                 cfg_rr_gap_en,
   input  logic                 cfg_wr_gap_en,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [AREA_W-1:0]    req_area,
   input  logic                 req_read,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W-1:0]    req_wdata,
   output logic [ADDR_W-1:0]    bus_addr,
   output logic [DATA_W-1:0]    bus_dout,
   output logic                 bus_dout_oe,
   output logic [NUM_AREAS-1:0] bus_cs,
   output logic                 bus_rd,
   output logic                 bus_wr,
   output logic [2:0]           bus_state
);
   localparam logic OFF = ACT_LOW ? 1'b1 : 1'b0;

   generate
      if (NUM_AREAS < 2 || NUM_AREAS > 64) begin : g_bad_areas
         $error("NUM_AREAS must lie in 2..64");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("address and data widths must be positive");
      end
   endgenerate

   logic              rr_en, wr_en;
   logic              gap_need, accept, back2back;
   bstate_e           state;
   logic              cur_read;
   logic [AREA_W-1:0] cur_area;

   ebus_gap_cfg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (cfg_load),
      .rr_in (cfg_rr_gap_en),
      .wr_in (cfg_wr_gap_en),
      .rr_en (rr_en),
      .wr_en (wr_en)
   );

   ebus_gap_judge #(.AREA_W(AREA_W)) u_judge (
      .back2back (back2back),
      .prev_read (cur_read),
      .prev_area (cur_area),
      .nxt_read  (req_read),
      .nxt_area  (req_area),
      .rr_en     (rr_en),
      .wr_en     (wr_en),
      .gap_need  (gap_need)
   );

   ebus_cycle_fsm #(
      .NUM_AREAS (NUM_AREAS),
      .AREA_W    (AREA_W),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .SLOW_MASK (SLOW_MASK)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_read  (req_read),
      .req_area  (req_area),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .gap_need  (gap_need),
      .req_ready (req_ready),
      .accept    (accept),
      .back2back (back2back),
      .state     (state),
      .cur_read  (cur_read),
      .cur_area  (cur_area),
      .cur_addr  (bus_addr),
      .cur_data  (bus_dout)
   );

   ebus_strobe_gen #(
      .NUM_AREAS (NUM_AREAS),
      .AREA_W    (AREA_W),
      .ACT_LOW   (ACT_LOW)
   ) u_strb (
      .state    (state),
      .cur_read (cur_read),
      .cur_area (cur_area),
      .cs       (bus_cs),
      .rd       (bus_rd),
      .wr       (bus_wr),
      .oe       (bus_dout_oe)
   );

   assign bus_state = state;

   // R3: the idle state drives no select and no strobe
   a_r3_ti_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TI) |-> (bus_rd == OFF && bus_wr == OFF &&
                            bus_cs == {NUM_AREAS{OFF}} && !bus_dout_oe));
   // R3: at most one area selected
   a_r3_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ACT_LOW ? ~bus_cs : bus_cs));
   // R4: write strobe never in T1
   a_r4_no_wr_t1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_T1) |-> (bus_wr == OFF));
   // R8: a gap never follows a write
   a_r8_no_gap_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !cur_read) |=> (state == ST_T1));
   // R9: a write taken after a read with the enable set goes to TI
   a_r9_war_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && back2back && cur_read && !req_read && wr_en) |=> (state == ST_TI));
endmodule

// File: tb/sim_ebus_idle_seq.sv
module sim_ebus_idle_seq;
   localparam int         NA   = 8;
   localparam int         AW   = 3;
   localparam int         ADW  = 16;
   localparam int         DW   = 16;
   localparam logic [7:0] SLOW = 8'b0000_0101;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic           rst_n, cfg_load, cfg_rr_gap_en, cfg_wr_gap_en;
   logic           req_valid, req_ready, req_read;
   logic [AW-1:0]  req_area;
   logic [ADW-1:0] req_addr, bus_addr;
   logic [DW-1:0]  req_wdata, bus_dout;
   logic           bus_dout_oe, bus_rd, bus_wr;
   logic [NA-1:0]  bus_cs;
   logic [2:0]     bus_state;

   ebus_idle_seq #(.NUM_AREAS(NA), .ADDR_W(ADW), .DATA_W(DW),
                   .SLOW_MASK(SLOW), .ACT_LOW(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
      .cfg_rr_gap_en(cfg_rr_gap_en), .cfg_wr_gap_en(cfg_wr_gap_en),
      .req_valid(req_valid), .req_ready(req_ready), .req_area(req_area),
      .req_read(req_read), .req_addr(req_addr), .req_wdata(req_wdata),
      .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_dout_oe(bus_dout_oe),
      .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_state(bus_state));

   int errs = 0, checks = 0;
   int m_state, m_area, m_read, m_addr, m_data, m_rr, m_wr;
   int q_area[16], q_read[16], q_addr[16], q_data[16], q_pause[16];
   int qn, qi, pcnt, gapcnt;
   logic drv_load, drv_rr, drv_wr;

   task automatic check(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int m_ready();
      return (m_state == 0) || (m_state == 4) || (m_state == 3 && !SLOW[m_area]);
   endfunction

   task automatic step();
      int rdy, gap;
      @(negedge clk);
      check("R2 state", bus_state, m_state);
      check("R5 ready", req_ready, m_ready());
      check("R3 cs", bus_cs, (m_state >= 2) ? (longint'(1) << m_area) : 0);
      check("R3 rd", bus_rd, (m_state >= 2 && m_read != 0));
      check("R4 wr", bus_wr, (m_state >= 3 && m_read == 0));
      check("R4 oe", bus_dout_oe, (m_state >= 2 && m_read == 0));
      if (m_state >= 2) check("R2 addr", bus_addr, m_addr);
      if (m_state >= 2 && m_read == 0) check("R4 data", bus_dout, m_data);
      if (bus_state == 3'd1) gapcnt++;
      req_valid = 1'b0;
      if (qi < qn) begin
         if (pcnt > 0) pcnt--;
         else begin
            req_valid = 1'b1;
            req_area  = AW'(q_area[qi]);
            req_read  = q_read[qi][0];
            req_addr  = ADW'(q_addr[qi]);
            req_wdata = DW'(q_data[qi]);
         end
      end
      cfg_load = drv_load; cfg_rr_gap_en = drv_rr; cfg_wr_gap_en = drv_wr;
      drv_load = 1'b0;
      rdy = m_ready();
      if (req_valid && rdy != 0) begin
         gap = 0;
         if (m_state != 0 && m_read != 0) begin
            if (q_read[qi] != 0) gap = (m_rr != 0 && q_area[qi] != m_area);
            else                 gap = m_wr;
         end
         m_area = q_area[qi]; m_read = q_read[qi];
         m_addr = q_addr[qi]; m_data = q_data[qi];
         m_state = (gap != 0) ? 1 : 2;
         qi++;
         if (qi < qn) pcnt = q_pause[qi];
      end else begin
         case (m_state)
            1: m_state = 2;
            2: m_state = 3;
            3: m_state = SLOW[m_area] ? 4 : 0;
            default: m_state = 0;
         endcase
      end
      if (cfg_load) begin
         m_rr = cfg_rr_gap_en; m_wr = cfg_wr_gap_en;
      end
   endtask

   task automatic add(input int area, input int rd, input int pause);
      q_area[qn] = area; q_read[qn] = rd; q_pause[qn] = pause;
      q_addr[qn] = 16'h1000 + qn * 16'h0111 + area;
      q_data[qn] = 16'hA500 + qn * 16'h0013;
      qn++;
   endtask

   task automatic set_cfg(input logic rr, input logic wr);
      drv_load = 1'b1; drv_rr = rr; drv_wr = wr;
      qn = 0; qi = 0;
      step();
   endtask

   task automatic run_scn(input string tag, input int exp_gaps);
      int n;
      gapcnt = 0; qi = 0; pcnt = q_pause[0];
      n = 0;
      while (!(qi >= qn && m_state == 0) && n < 200) begin
         step(); n++;
      end
      step();
      check({tag, " finished"}, (n < 200), 1);
      check({tag, " idle-state count"}, gapcnt, exp_gaps);
      qn = 0;
   endtask

   initial begin
      #2000000;
      checks++; errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cfg_load = 1'b0; cfg_rr_gap_en = 1'b0; cfg_wr_gap_en = 1'b0;
      req_valid = 1'b0; req_area = '0; req_read = 1'b0; req_addr = '0; req_wdata = '0;
      drv_load = 1'b0; drv_rr = 1'b0; drv_wr = 1'b0;
      m_state = 0; m_area = 0; m_read = 0; m_addr = 0; m_data = 0; m_rr = 1; m_wr = 1;
      qn = 0; qi = 0; pcnt = 0; gapcnt = 0;
      repeat (3) @(negedge clk);
      // R1: state during reset
      check("R1 reset state", bus_state, 0);
      check("R1 reset ready", req_ready, 1);
      check("R1 reset strobes", {bus_cs, bus_rd, bus_wr, bus_dout_oe}, 0);
      rst_n = 1'b1;
      step();
      // R10 and R6: defaults on, read area 1 then read area 3 -> one gap
      add(1, 1, 0); add(3, 1, 0);
      run_scn("R10 R6", 1);
      // R8: same-area reads on a slow area
      add(0, 1, 0); add(0, 1, 0);
      run_scn("R8 same area", 0);
      // R8: read after write, then same-area read
      add(4, 0, 0); add(5, 1, 0); add(5, 1, 0);
      run_scn("R8 after write", 0);
      // R9: write after read, enable set
      add(1, 1, 0); add(1, 0, 0);
      run_scn("R9 enabled", 1);
      // R7: area-change gap off, write-after-read still on
      set_cfg(1'b0, 1'b1);
      add(1, 1, 0); add(6, 1, 0); add(2, 0, 0);
      run_scn("R7", 1);
      // R9: write-after-read gap off
      set_cfg(1'b1, 1'b0);
      add(2, 1, 0); add(3, 0, 0);
      run_scn("R9 disabled", 0);
      // R11: pause between reads to different areas
      set_cfg(1'b1, 1'b1);
      add(3, 1, 0); add(5, 1, 3);
      run_scn("R11", 0);
      // R6: mixed back-to-back stream
      add(0, 1, 0); add(1, 1, 0); add(1, 0, 0); add(1, 1, 0); add(2, 1, 0); add(7, 0, 0);
      run_scn("R6 mixed", 4);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule